// File: doc/BRIEF.md
# I2C Controller Status Flags and Interrupt Combiner

This unit keeps the ten status flags of an I2C controller and folds them into one level interrupt. A transfer engine, outside this block, reports what happens on the wire through one-cycle event strobes: a byte received, a byte handed to the shifter, a frame started, STOP finished, NACK, arbitration lost, underrun, an own-address match with its direction, and a general-call match. The bus side gives strobes for a status read, a receive-holding read, a transmit-holding write and controller enable, plus write-one-to-set and write-one-to-clear strobes for the interrupt mask.

Each flag follows its own set and clear rule, and a set always beats a clear in the same cycle, so no event is lost. The transfer-complete flag comes from a three-state phase machine. `PH_OFF` is the reset state. It moves to `PH_IDLE` on enable or on a finishing event (STOP, NACK, arbitration loss). `PH_IDLE` moves to `PH_BUSY` on a frame start, unless a finishing event or enable arrives in the same cycle. `PH_BUSY` returns to `PH_IDLE` on enable or on a finishing event. Transfer complete reads 1 only in `PH_IDLE`. Every strobe acts at the clock edge where it is sampled high, and the status word shows the result from the next cycle on.

Top module: `i2c_stat_irq`

## Requirements
- R1: After reset the status word is all zero, the mask is all zero and `irq` is 0. The status bits are: 0 transfer complete, 1 receive ready, 2 transmit ready, 3 slave read, 4 slave access, 5 general-call access, 6 overrun, 7 underrun, 8 NACK, 9 arbitration lost.
- R2: Transfer complete becomes 1 on enable, STOP done, NACK or arbitration loss. It becomes 0 on a frame start when none of those four arrives in the same cycle.
- R3: Receive ready is set by a received byte and cleared by a receive-holding read.
- R4: Transmit ready is cleared by a transmit-holding write. It is set by a byte moving to the shifter, by NACK, or by enable.
- R5: Overrun is set when a byte is received while receive ready is 1 and no receive-holding read happens in that cycle.
- R6: Overrun, underrun, slave access and general-call access are cleared by a status read only while transfer complete is 1. A status read while it is 0 leaves them unchanged.
- R7: NACK and arbitration lost each set their own flag and transfer complete in the same update. Any status read clears both.
- R8: Slave read holds the direction given with the last address match (1 = read). The status bit shows it only while slave access is 1 and reads 0 otherwise.
- R9: A mask-enable write sets the mask bits where the data is 1. A mask-disable write clears them. When both are written in one cycle, enable wins for a bit set in both.
- R10: `irq` is 1 exactly when some status bit and its mask bit are both 1.
- R11: When a set event and a clearing strobe for the same flag come in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_rx_byte | input | 1 | Byte placed in the receive holding register |
| ev_tx_shift | input | 1 | Transmit holding byte moved to the shifter |
| ev_frame_start | input | 1 | Frame begins on the bus |
| ev_stop_done | input | 1 | STOP sent or received, holding and shift registers empty |
| ev_nack | input | 1 | Byte not acknowledged |
| ev_arb_lost | input | 1 | Arbitration lost to another master |
| ev_underrun | input | 1 | Shifter needed data while the holding register was empty |
| ev_slv_match | input | 1 | Own slave address matched |
| ev_slv_dir | input | 1 | Direction of the match, 1 = read |
| ev_gc_match | input | 1 | General-call address matched |
| bus_stat_rd | input | 1 | Status word read |
| bus_rhr_rd | input | 1 | Receive holding register read |
| bus_thr_wr | input | 1 | Transmit holding register write |
| bus_enable | input | 1 | Master enable strobe |
| bus_ien_wr | input | 1 | Mask enable write (write one to set) |
| bus_idis_wr | input | 1 | Mask disable write (write one to clear) |
| bus_wdata | input | WIDTH | Data for mask writes |
| status | output | WIDTH | Status word |
| irq | output | 1 | Level interrupt |

## Verification
The flags are driven one strobe at a time, and then with a set event and a clearing strobe in the same cycle, which tells apart a flag whose set has priority from one whose clear has priority. Status reads are issued both inside a frame and after it has ended, which tells the sticky group, cleared only after the frame ends, from NACK and arbitration lost, cleared by any read. Slave matches are made with both direction values and then followed by a clearing read, to show that the slave-read bit follows slave access. The mask is written with enable alone, disable alone and both together, while the set of active status bits changes, so the interrupt is seen to follow exactly the masked bits.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
    localparam int STAT_W = 10;

    localparam int B_TXC = 0;
    localparam int B_RXR = 1;
    localparam int B_TXR = 2;
    localparam int B_SVR = 3;
    localparam int B_SVA = 4;
    localparam int B_GCA = 5;
    localparam int B_OVR = 6;
    localparam int B_UNR = 7;
    localparam int B_NAK = 8;
    localparam int B_ARB = 9;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_IDLE = 2'd1,
        PH_BUSY = 2'd2
    } phase_t;
endpackage

// File: rtl/i2c_stat_phase.sv
module i2c_stat_phase
    import i2c_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic frame_start,
    input  logic finish,
    output logic txcomp
);
    phase_t state_q;
    phase_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_OFF: begin
                if (enable || finish) state_d = PH_IDLE;
            end
            PH_IDLE: begin
                if (!(enable || finish) && frame_start) state_d = PH_BUSY;
            end
            PH_BUSY: begin
                if (enable || finish) state_d = PH_IDLE;
            end
            default: state_d = PH_OFF;
        endcase
    end

    always_comb begin
        txcomp = (state_q == PH_IDLE);
    end
endmodule

// File: rtl/i2c_flag_cell.sv
module i2c_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
    import i2c_stat_pkg::*;
#(
    parameter int WIDTH = STAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txcomp,
    input  logic             ev_rx_byte,
    input  logic             ev_tx_shift,
    input  logic             ev_nack,
    input  logic             ev_arb_lost,
    input  logic             ev_underrun,
    input  logic             ev_slv_match,
    input  logic             ev_slv_dir,
    input  logic             ev_gc_match,
    input  logic             bus_stat_rd,
    input  logic             bus_rhr_rd,
    input  logic             bus_thr_wr,
    input  logic             bus_enable,
    output logic [WIDTH-1:1] flag_q
);
    logic [WIDTH-1:1] set_v;
    logic [WIDTH-1:1] clr_v;
    logic             sticky_clr;

    always_comb begin
        sticky_clr = bus_stat_rd & txcomp;
        set_v = '0;
        clr_v = '0;
        set_v[B_RXR] = ev_rx_byte;
        clr_v[B_RXR] = bus_rhr_rd;
        set_v[B_TXR] = ev_tx_shift | ev_nack | bus_enable;
        clr_v[B_TXR] = bus_thr_wr;
        set_v[B_SVR] = ev_slv_match & ev_slv_dir;
        clr_v[B_SVR] = ev_slv_match & ~ev_slv_dir;
        set_v[B_SVA] = ev_slv_match;
        clr_v[B_SVA] = sticky_clr;
        set_v[B_GCA] = ev_gc_match;
        clr_v[B_GCA] = sticky_clr;
        set_v[B_OVR] = ev_rx_byte & flag_q[B_RXR] & ~bus_rhr_rd;
        clr_v[B_OVR] = sticky_clr;
        set_v[B_UNR] = ev_underrun;
        clr_v[B_UNR] = sticky_clr;
        set_v[B_NAK] = ev_nack;
        clr_v[B_NAK] = bus_stat_rd;
        set_v[B_ARB] = ev_arb_lost;
        clr_v[B_ARB] = bus_stat_rd;
    end

    for (genvar i = 1; i < WIDTH; i++) begin : g_cell
        i2c_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_v[i]),
            .clr   (clr_v[i]),
            .q     (flag_q[i])
        );
    end
endmodule

// File: rtl/i2c_irq_mask.sv
module i2c_irq_mask #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_wr,
    input  logic             idis_wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] status,
    output logic             irq
);
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (idis_wr) mask_d = mask_d & ~wdata;
        if (ien_wr)  mask_d = mask_d | wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    always_comb begin
        irq = |(status & mask_q);
    end
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq
    import i2c_stat_pkg::*;
#(
    parameter int WIDTH = STAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_rx_byte,
    input  logic             ev_tx_shift,
    input  logic             ev_frame_start,
    input  logic             ev_stop_done,
    input  logic             ev_nack,
    input  logic             ev_arb_lost,
    input  logic             ev_underrun,
    input  logic             ev_slv_match,
    input  logic             ev_slv_dir,
    input  logic             ev_gc_match,
    input  logic             bus_stat_rd,
    input  logic             bus_rhr_rd,
    input  logic             bus_thr_wr,
    input  logic             bus_enable,
    input  logic             bus_ien_wr,
    input  logic             bus_idis_wr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] status,
    output logic             irq
);
    logic             txcomp;
    logic             finish;
    logic [WIDTH-1:1] flag_q;

    assign finish = ev_stop_done | ev_nack | ev_arb_lost;

    i2c_stat_phase u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (bus_enable),
        .frame_start (ev_frame_start),
        .finish      (finish),
        .txcomp      (txcomp)
    );

    i2c_stat_flags #(.WIDTH(WIDTH)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .txcomp       (txcomp),
        .ev_rx_byte   (ev_rx_byte),
        .ev_tx_shift  (ev_tx_shift),
        .ev_nack      (ev_nack),
        .ev_arb_lost  (ev_arb_lost),
        .ev_underrun  (ev_underrun),
        .ev_slv_match (ev_slv_match),
        .ev_slv_dir   (ev_slv_dir),
        .ev_gc_match  (ev_gc_match),
        .bus_stat_rd  (bus_stat_rd),
        .bus_rhr_rd   (bus_rhr_rd),
        .bus_thr_wr   (bus_thr_wr),
        .bus_enable   (bus_enable),
        .flag_q       (flag_q)
    );

    always_comb begin
        status         = {flag_q, txcomp};
        status[B_SVR]  = flag_q[B_SVR] & flag_q[B_SVA];
    end

    i2c_irq_mask #(.WIDTH(WIDTH)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .ien_wr  (bus_ien_wr),
        .idis_wr (bus_idis_wr),
        .wdata   (bus_wdata),
        .status  (status),
        .irq     (irq)
    );
endmodule

// File: rtl/i2c_stat_chk.sv
module i2c_stat_chk #(
    parameter int WIDTH = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_rx_byte,
    input logic             ev_tx_shift,
    input logic             ev_nack,
    input logic             ev_underrun,
    input logic             bus_stat_rd,
    input logic             bus_rhr_rd,
    input logic             bus_thr_wr,
    input logic             bus_enable,
    input logic             bus_ien_wr,
    input logic             bus_idis_wr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] status,
    input logic             irq
);
    assert_enable_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_enable |=> (status[0] && status[2]));

    assert_rx_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_byte |=> status[1]);

    assert_thr_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_thr_wr && !ev_tx_shift && !ev_nack && !bus_enable) |=> !status[2]);

    assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_byte && status[1] && !bus_rhr_rd) |=> status[6]);

    assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stat_rd && !status[0] && status[7]) |=> status[7]);

    assert_nack_txcomp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> (status[8] && status[0]));

    assert_svread_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !status[4] |-> !status[3]);

    assert_mask_all_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idis_wr && !bus_ien_wr && (&bus_wdata)) |=> !irq);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    assert_underrun_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_underrun && bus_stat_rd) |=> status[7]);
endmodule

bind i2c_stat_irq i2c_stat_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_rx_byte  (ev_rx_byte),
    .ev_tx_shift (ev_tx_shift),
    .ev_nack     (ev_nack),
    .ev_underrun (ev_underrun),
    .bus_stat_rd (bus_stat_rd),
    .bus_rhr_rd  (bus_rhr_rd),
    .bus_thr_wr  (bus_thr_wr),
    .bus_enable  (bus_enable),
    .bus_ien_wr  (bus_ien_wr),
    .bus_idis_wr (bus_idis_wr),
    .bus_wdata   (bus_wdata),
    .status      (status),
    .irq         (irq)
);

// File: tb/sim_i2c_stat_irq.sv
`timescale 1ns/1ps
module sim_i2c_stat_irq;
    localparam int W = 10;

    localparam logic [15:0] S_RX   = 16'h0001;
    localparam logic [15:0] S_TXS  = 16'h0002;
    localparam logic [15:0] S_FST  = 16'h0004;
    localparam logic [15:0] S_STOP = 16'h0008;
    localparam logic [15:0] S_NACK = 16'h0010;
    localparam logic [15:0] S_ARB  = 16'h0020;
    localparam logic [15:0] S_UNR  = 16'h0040;
    localparam logic [15:0] S_SLV  = 16'h0080;
    localparam logic [15:0] S_DIR  = 16'h0100;
    localparam logic [15:0] S_GC   = 16'h0200;
    localparam logic [15:0] S_SRD  = 16'h0400;
    localparam logic [15:0] S_RHR  = 16'h0800;
    localparam logic [15:0] S_THR  = 16'h1000;
    localparam logic [15:0] S_EN   = 16'h2000;
    localparam logic [15:0] S_IEN  = 16'h4000;
    localparam logic [15:0] S_IDIS = 16'h8000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] stim = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] status;
    logic irq;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int        q_due[$];
    logic [W-1:0] q_st[$];
    logic      q_irq[$];
    string     q_tag[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_stat_irq #(.WIDTH(W)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_rx_byte     (stim[0]),
        .ev_tx_shift    (stim[1]),
        .ev_frame_start (stim[2]),
        .ev_stop_done   (stim[3]),
        .ev_nack        (stim[4]),
        .ev_arb_lost    (stim[5]),
        .ev_underrun    (stim[6]),
        .ev_slv_match   (stim[7]),
        .ev_slv_dir     (stim[8]),
        .ev_gc_match    (stim[9]),
        .bus_stat_rd    (stim[10]),
        .bus_rhr_rd     (stim[11]),
        .bus_thr_wr     (stim[12]),
        .bus_enable     (stim[13]),
        .bus_ien_wr     (stim[14]),
        .bus_idis_wr    (stim[15]),
        .bus_wdata      (wdata),
        .status         (status),
        .irq            (irq)
    );

    task automatic compare(input logic [W-1:0] es, input logic ei, input string tag);
        checks++;
        if (status !== es || irq !== ei) begin
            failures++;
            $display("FAIL %s: status=%03h irq=%0b expected status=%03h irq=%0b",
                     tag, status, irq, es, ei);
        end
    endtask

    // Driver: applies one cycle of strobes and queues the expected result
    task automatic step(input logic [15:0] s, input logic [W-1:0] wd,
                        input logic [W-1:0] es, input logic ei, input string tag);
        @(negedge clk);
        stim  = s;
        wdata = wd;
        q_due.push_back(cyc + 1);
        q_st.push_back(es);
        q_irq.push_back(ei);
        q_tag.push_back(tag);
    endtask

    // Monitor: pops and compares expected items when they fall due
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] == cyc) begin
            compare(q_st[0], q_irq[0], q_tag[0]);
            void'(q_due.pop_front());
            void'(q_st.pop_front());
            void'(q_irq.pop_front());
            void'(q_tag.pop_front());
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare(10'h000, 1'b0, "R1 reset state");

        step(S_EN,          10'h000, 10'h005, 1'b0, "R2 R4 enable sets txcomp and txrdy");
        step(S_IEN,         10'h3FF, 10'h005, 1'b1, "R9 R10 mask enable all");
        step(S_IDIS,        10'h005, 10'h005, 1'b0, "R9 mask disable bits 0 and 2");
        step(S_FST,         10'h000, 10'h004, 1'b0, "R2 frame start clears txcomp");
        step(S_THR,         10'h000, 10'h000, 1'b0, "R4 thr write clears txrdy");
        step(S_TXS,         10'h000, 10'h004, 1'b0, "R4 shift sets txrdy");
        step(S_THR | S_TXS, 10'h000, 10'h004, 1'b0, "R11 shift beats thr write");
        step(S_RX,          10'h000, 10'h006, 1'b1, "R3 byte received");
        step(S_RX,          10'h000, 10'h046, 1'b1, "R5 overrun on second byte");
        step(S_UNR,         10'h000, 10'h0C6, 1'b1, "R6 underrun set");
        step(S_SRD,         10'h000, 10'h0C6, 1'b1, "R6 read in frame keeps sticky");
        step(S_RHR,         10'h000, 10'h0C4, 1'b1, "R3 rhr read clears rxrdy");
        step(S_RX | S_RHR,  10'h000, 10'h0C6, 1'b1, "R11 R5 receive beats read, no overrun");
        step(S_STOP,        10'h000, 10'h0C7, 1'b1, "R2 stop sets txcomp");
        step(S_SRD,         10'h000, 10'h007, 1'b1, "R6 read after frame clears sticky");
        step(S_RHR,         10'h000, 10'h005, 1'b0, "R10 only masked-out bits remain");
        step(S_FST | S_STOP,10'h000, 10'h005, 1'b0, "R2 R11 finish beats frame start");
        step(S_FST,         10'h000, 10'h004, 1'b0, "R2 frame start");
        step(S_SLV | S_DIR, 10'h000, 10'h01C, 1'b1, "R8 slave match read direction");
        step(S_GC,          10'h000, 10'h03C, 1'b1, "R6 general call set");
        step(S_SRD,         10'h000, 10'h03C, 1'b1, "R6 read in frame keeps access flags");
        step(S_THR | S_NACK,10'h000, 10'h13D, 1'b1, "R7 R4 nack sets txcomp and txrdy");
        step(S_SRD,         10'h000, 10'h005, 1'b0, "R7 R8 read clears nack and access");
        step(S_FST,         10'h000, 10'h004, 1'b0, "R2 frame start");
        step(S_SLV,         10'h000, 10'h014, 1'b1, "R8 slave match write direction");
        step(S_ARB | S_SRD, 10'h000, 10'h215, 1'b1, "R7 R11 arbitration loss beats read");
        step(S_SRD,         10'h000, 10'h005, 1'b0, "R7 R6 read clears arbitration and access");
        step(S_IEN | S_IDIS,10'h001, 10'h005, 1'b1, "R9 enable wins over disable");
        step(S_IDIS,        10'h3FF, 10'h005, 1'b0, "R9 R10 mask all off");
        step(S_UNR | S_SRD, 10'h000, 10'h085, 1'b0, "R11 underrun beats clearing read");
        step(S_SRD,         10'h000, 10'h005, 1'b0, "R6 underrun cleared");
        step(S_FST,         10'h000, 10'h004, 1'b0, "R2 frame start");
        step(S_THR,         10'h000, 10'h000, 1'b0, "R4 thr write");
        step(S_EN,          10'h000, 10'h005, 1'b0, "R2 R4 enable ends frame");
        step(16'h0000,      10'h000, 10'h005, 1'b0, "R1 idle holds");

        @(negedge clk);
        stim = '0;
        while (q_due.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule